// File: doc/BRIEF.md
# Dual Prescaled Down-Counter with Capture

The block holds two 16-bit down-counters. Each one advances on a tick from its own power-of-two prescaler, which divides the system clock by 2 up to 256. When a counter is at zero and a tick arrives, it reloads from its reload constant and raises a one-clock terminal-count pulse. Each counter also has a 16-bit capture register. This register takes a snapshot of the running count when its external event pin rises, or when software issues a capture command over the register bus.

Two modes change the plain countdown. In alternating-reload mode the capture register becomes a second reload constant, so successive periods alternate between the two values. In chained mode the two counters form a single 32-bit count. Counter 0 then runs from counter 1's prescaler, and counter 1 steps once each time counter 0 reloads. All control goes through a byte-wide register bus with single-cycle writes and combinational reads.

Top module: `tcap_timer_pair`

## Requirements
- R1: The divider-select register at address 0 holds counter 1's 3-bit code in bits 7:5 and counter 0's code in bits 2:0. It resets to 0x21, and bits 4:3 always read 0.
- R2: With its run bit set and divider code s, a counter decrements once every 2^(s+1) clocks. Setting the run bit restarts the divider phase, so the first decrement comes 2^(s+1) clocks after the run write.
- R3: A tick that finds the count at zero reloads the primary constant when alternating-reload mode is off. The same event drives tc_o[c] high for exactly one clock, in the cycle after the reload.
- R4: Writing the command register (address 2) with bit 2+c set loads counter c with its primary constant at once. A load takes precedence over a tick in the same cycle.
- R5: Writing the command register with bit c set copies counter c's count into its capture register. The capture register sits at address 8+2c (low byte) and 9+2c (high byte), and the bus can also write it.
- R6: A rising edge on ext_evt[c] passes through a two-stage synchroniser and then copies counter c's count into its capture register. Holding the pin high does not capture again.
- R7: With mode bit 2+c set (alternating reload), counter c reloads alternately from its capture register and its primary constant. After a load, the first reload at zero uses the capture register.
- R8: With mode bit 4 set (chained), counter 0 ticks from counter 1's divider and its own divider code is ignored. Counter 1 decrements only in the cycle in which counter 0 reloads.
- R9: Mode bits 1:0 are the run bits of counters 1:0, and a cleared run bit holds the count. The mode register (address 1) reads back. The primary constant of counter c sits at address 4+2c/5+2c and its count reads at address 12+2c/13+2c, low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per byte written |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| ext_evt | input | 2 | Asynchronous capture event pins, one per counter |
| tc_o | output | 2 | One-clock terminal-count pulses, one per counter |

## Verification
The bench builds the block with the default parameters: 8-bit data, an 8-bit divider and a two-stage synchroniser. With these values every divider code from 2 to 256 is reachable, and the 16-bit counts can be read a byte at a time. The bench opens and closes the run bit over exact clock windows, so the number of ticks follows directly from the divider code. This brings the divide-by-2 and divide-by-16 rates, reload at zero, alternation between two reload values and the chained 32-bit count within a few hundred clocks. Directed tests cover pin-driven capture with the pin held high, and count the terminal pulses when a zero reload constant makes every tick a reload.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int NUM_CH = 2;

  localparam logic [3:0] ADDR_PSEL = 4'h0;
  localparam logic [3:0] ADDR_MODE = 4'h1;
  localparam logic [3:0] ADDR_CMD  = 4'h2;
  localparam logic [3:0] ADDR_TC   = 4'h4;
  localparam logic [3:0] ADDR_CAP  = 4'h8;
  localparam logic [3:0] ADDR_CNT  = 4'hC;

  // mode register layout: bit 4 chained, bits 3:2 alternating reload, bits 1:0 run
  typedef struct packed {
    logic       chain;
    logic [1:0] bival;
    logic [1:0] run;
  } mode_t;
endpackage

// File: rtl/tcap_prescaler.sv
module tcap_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [$clog2(PRE_W)-1:0] sel,
  output logic                     tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i <= int'(sel));
    end
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_comb begin
    pre_d = pre_q;
    if (run) pre_d = pre_q + 1'b1;
    else     pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // the smallest divide is 2, so ticks are never adjacent
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb sync_d = {sync_q[STAGES-2:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      load,
  input  logic                      bival,
  input  logic [CNT_W-1:0]          prim_val,
  input  logic                      cap_evt,
  input  logic [CNT_W/BYTE_W-1:0]   cap_we,
  input  logic [BYTE_W-1:0]         cap_wdata,
  output logic [CNT_W-1:0]          cnt,
  output logic [CNT_W-1:0]          cap,
  output logic                      wrap,
  output logic                      tc
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             alt_q, alt_d;
  logic             tc_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap    = tick && !load && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    alt_d = alt_q;
    if (load) begin
      cnt_d = prim_val;
      alt_d = 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        if (bival && !alt_q) begin
          cnt_d = cap_q;
          alt_d = 1'b1;
        end else begin
          cnt_d = prim_val;
          alt_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    cap_d = cap_q;
    for (int b = 0; b < NB; b++) begin
      if (cap_we[b])    cap_d[b*BYTE_W +: BYTE_W] = cap_wdata;
      else if (cap_evt) cap_d[b*BYTE_W +: BYTE_W] = cnt_q[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alt_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      alt_q <= alt_d;
      tc_q  <= wrap;
    end
  end

  // capture contents are left undefined by reset
  always_ff @(posedge clk) begin
    cap_q <= cap_d;
  end

  assign cnt = cnt_q;
  assign cap = cap_q;
  assign tc  = tc_q;

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_zero) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(prim_val));
  assert_reload_primary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !bival) |=> (cnt_q == $past(prim_val)) && tc_q);
  assert_tc_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && bival) |=> cnt_q == ($past(alt_q) ? $past(prim_val) : $past(cap_q)));
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_we == '0) |=> cap_q == $past(cnt_q));
endmodule

// File: rtl/tcap_timer_pair.sv
module tcap_timer_pair
  import tcap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        ext_evt,
  output logic [1:0]        tc_o
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int NB     = CNT_W / DATA_W;
  localparam int SEL_W  = $clog2(PRE_W);
  localparam int MODE_W = $bits(mode_t);

  logic [NUM_CH-1:0][SEL_W-1:0] sel_q, sel_d;
  logic [NUM_CH-1:0][CNT_W-1:0] prim_q, prim_d;
  mode_t                        mode_q, mode_d;

  logic [NUM_CH-1:0]            load, swcap, pre_run, pre_tick, tick, wrap, rise, cap_evt;
  logic [NUM_CH-1:0][NB-1:0]    cap_we;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt, cap;
  logic                         cmd_hit;

  // ---------------- register next state ----------------
  always_comb begin
    sel_d  = sel_q;
    mode_d = mode_q;
    prim_d = prim_q;
    if (bus_wr && bus_addr == ADDR_PSEL) begin
      sel_d[0] = bus_wdata[SEL_W-1:0];
      sel_d[1] = bus_wdata[DATA_W-1 -: SEL_W];
    end
    if (bus_wr && bus_addr == ADDR_MODE) begin
      mode_d = mode_t'(bus_wdata[MODE_W-1:0]);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < NB; b++) begin
        if (bus_wr && bus_addr == ADDR_TC + 4'(NB*c + b))
          prim_d[c][b*DATA_W +: DATA_W] = bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= {NUM_CH{SEL_W'(1)}};
      mode_q <= '0;
      prim_q <= '0;
    end else begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
      prim_q <= prim_d;
    end
  end

  // ---------------- commands and capture writes ----------------
  assign cmd_hit = bus_wr && (bus_addr == ADDR_CMD);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      swcap[c] = cmd_hit && bus_wdata[c];
      load[c]  = cmd_hit && bus_wdata[NUM_CH + c];
      for (int b = 0; b < NB; b++) begin
        cap_we[c][b] = bus_wr && (bus_addr == ADDR_CAP + 4'(NB*c + b));
      end
    end
  end

  // ---------------- tick routing ----------------
  assign pre_run[0] = mode_q.run[0] && !mode_q.chain;
  assign pre_run[1] = mode_q.run[1] || (mode_q.chain && mode_q.run[0]);
  assign tick[0]    = mode_q.chain ? (pre_tick[1] && mode_q.run[0]) : pre_tick[0];
  assign tick[1]    = mode_q.chain ? (wrap[0] && mode_q.run[1]) : pre_tick[1];

  // ---------------- per-channel datapath ----------------
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tcap_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (pre_run[c]),
      .sel  (sel_q[c]),
      .tick (pre_tick[c])
    );

    tcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (ext_evt[c]),
      .rise (rise[c])
    );

    assign cap_evt[c] = rise[c] || swcap[c];

    tcap_channel #(.CNT_W(CNT_W), .BYTE_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick[c]),
      .load     (load[c]),
      .bival    (mode_q.bival[c]),
      .prim_val (prim_q[c]),
      .cap_evt  (cap_evt[c]),
      .cap_we   (cap_we[c]),
      .cap_wdata(bus_wdata),
      .cnt      (cnt[c]),
      .cap      (cap[c]),
      .wrap     (wrap[c]),
      .tc       (tc_o[c])
    );
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_PSEL) begin
      bus_rdata[SEL_W-1:0]         = sel_q[0];
      bus_rdata[DATA_W-1 -: SEL_W] = sel_q[1];
    end
    if (bus_addr == ADDR_MODE) bus_rdata[MODE_W-1:0] = mode_q;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < NB; b++) begin
        if (bus_addr == ADDR_TC  + 4'(NB*c + b)) bus_rdata = prim_q[c][b*DATA_W +: DATA_W];
        if (bus_addr == ADDR_CAP + 4'(NB*c + b)) bus_rdata = cap[c][b*DATA_W +: DATA_W];
        if (bus_addr == ADDR_CNT + 4'(NB*c + b)) bus_rdata = cnt[c][b*DATA_W +: DATA_W];
      end
    end
  end

  // chained: the high half moves only when the low half reloads
  assert_chain_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.chain && !load[1] && !wrap[0]) |=> $stable(cnt[1]));
  assert_chain_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.chain |-> !pre_tick[0]);
  assert_sel_unused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_PSEL) |-> bus_rdata[DATA_W-SEL_W-1:SEL_W] == '0);
endmodule

// File: tb/tb_tcap_timer_pair.sv
module tb_tcap_timer_pair;
  localparam int CLK_NS = 8;
  localparam int NSTEP  = 55;
  localparam logic [3:0] OP_WR = 4'h0, OP_RD = 4'h1, OP_IDLE = 4'h2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] ext_evt = '0;
  logic [1:0] tc_o;

  int n_chk = 0;
  int n_fail = 0;
  int tc0_seen = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tcap_timer_pair dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_evt(ext_evt), .tc_o(tc_o)
  );

  always @(negedge clk) if (tc_o[0]) tc0_seen++;

  // word = {op, addr, data/idle count, expected, requirement}
  localparam logic [31:0] STEPS [NSTEP] = '{
    32'h0_0_20_00_01, // R1 select div2 on counter 0
    32'h0_4_03_00_04,
    32'h0_5_00_00_04,
    32'h0_2_04_00_04, // R4 load
    32'h1_C_00_03_04, // R4
    32'h1_D_00_00_04, // R4
    32'h0_1_01_00_02, // run
    32'h2_0_05_00_02,
    32'h0_1_00_00_02, // stop: 3 ticks
    32'h1_C_00_00_02, // R2
    32'h0_1_01_00_03,
    32'h2_0_01_00_03,
    32'h0_1_00_00_03, // one tick at zero
    32'h1_C_00_03_03, // R3 reload primary
    32'h2_0_03_00_09,
    32'h1_C_00_03_09, // R9 held while stopped
    32'h0_0_23_00_02, // div16
    32'h0_4_00_00_02,
    32'h0_5_01_00_02,
    32'h0_2_04_00_02,
    32'h1_D_00_01_04, // R4
    32'h1_4_00_00_09, // R9 constant readback
    32'h1_5_00_01_09, // R9
    32'h0_1_01_00_02,
    32'h2_0_4F_00_02,
    32'h0_1_00_00_02, // 80 clocks = 5 ticks
    32'h1_C_00_FB_02, // R2
    32'h1_D_00_00_02, // R2
    32'h0_2_01_00_05, // R5 software capture
    32'h1_8_00_FB_05, // R5
    32'h1_9_00_00_05, // R5
    32'h0_0_20_00_07,
    32'h0_4_02_00_07,
    32'h0_5_00_00_07,
    32'h0_8_05_00_07,
    32'h0_9_00_00_07,
    32'h0_2_04_00_07,
    32'h0_1_05_00_07, // run + alternate
    32'h2_0_07_00_07,
    32'h0_1_04_00_07, // 4 ticks: 2,1,0,5,4
    32'h1_C_00_04_07, // R7 alternate value used
    32'h1_1_00_04_09, // R9 mode readback
    32'h0_1_05_00_07,
    32'h2_0_09_00_07,
    32'h0_1_04_00_07, // 5 more ticks back to primary
    32'h1_C_00_02_07, // R7
    32'h0_0_03_00_08, // counter1 div2, counter0 div16 (ignored)
    32'h0_4_01_00_08,
    32'h0_6_02_00_08,
    32'h0_2_0C_00_08,
    32'h0_1_13_00_08, // chained run
    32'h2_0_05_00_08,
    32'h0_1_10_00_08, // 3 low ticks
    32'h1_C_00_00_08, // R8
    32'h1_E_00_01_08  // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    bus_addr = a;
    #2;
    check(req, bus_rdata, exp);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'h0, 8'h21, "R1 reset divider codes");
    rd(4'h1, 8'h00, "R9 reset mode");
    rd(4'hC, 8'h00, "R9 reset count");

    for (int i = 0; i < NSTEP; i++) begin
      logic [31:0] w;
      string tag;
      w = STEPS[i];
      tag = $sformatf("R%0d step %0d", w[7:0], i);
      case (w[31:28])
        OP_WR:   wr(w[27:24], w[23:16]);
        OP_RD:   rd(w[27:24], w[15:8], tag);
        default: repeat (w[23:16]) @(negedge clk);
      endcase
    end

    // R1 unused bits read zero
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'hE7, "R1 unused bits");

    // R6 pin-driven capture on counter 1 (stopped)
    wr(4'h1, 8'h00);
    wr(4'h6, 8'h34);
    wr(4'h7, 8'h12);
    wr(4'h2, 8'h08);
    ext_evt[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'hA, 8'h34, "R6 pin capture low");
    rd(4'hB, 8'h12, "R6 pin capture high");
    wr(4'h6, 8'h55);
    wr(4'h7, 8'h00);
    wr(4'h2, 8'h08);
    repeat (5) @(negedge clk);
    rd(4'hA, 8'h34, "R6 held pin no recapture");
    ext_evt[1] = 1'b0;
    repeat (4) @(negedge clk);
    ext_evt[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'hA, 8'h55, "R6 second edge capture");

    // R3 terminal pulses with zero reload: every tick reloads
    wr(4'h0, 8'h20);
    wr(4'h4, 8'h00);
    wr(4'h5, 8'h00);
    wr(4'h2, 8'h04);
    tc0_seen = 0;
    wr(4'h1, 8'h01);
    repeat (9) @(negedge clk);
    wr(4'h1, 8'h00);
    repeat (4) @(negedge clk);
    check("R3 terminal pulse count", 8'(tc0_seen), 8'd5);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule